// File: doc/BRIEF.md
# Flash Command Sequencer With Status

This block is the control core of a single byte-wide flash die, built as synthesizable logic. A host drives an asynchronous-style bus (active-low chip enable, output enable and write enable, a 19-bit address and an 8-bit data bus). The bus is sampled on the block clock. Multi-write command sequences written over this bus are decoded into program, sector-erase and chip-erase operations. These run against a small register array that stands in for the flash cells: 8 sectors of `SECT_BYTES` bytes each.

Each operation lasts a fixed number of clock cycles, set by parameters. While an operation runs, or while the sector-erase collection window is open, every read returns a status byte instead of array data. The status byte carries a polling bit, a toggle bit, a time-limit bit and an erase-started bit. Host software polls this byte until the block returns to read mode by itself.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in read mode and every array byte reads 8'hFF. Reads return array data with no command written first.
- R2: A bus write is taken only while ce_n=0, we_n=0 and oe_n=1. A write pulse with oe_n=0 or ce_n=1 has no effect on the array or on the command state.
- R3: A write takes the address present in its first active cycle and the data present in its last active cycle. The write is committed on the clock edge after the pulse ends.
- R4: Program is four writes: 8'hAA to address 16'h555, 8'h55 to 16'h2AA, 8'hA0 to 16'h555, then the target address and data. Command addresses are decoded on addr[15:0]. The target byte becomes old & data after PROG_CYC cycles, and the block then returns to read mode.
- R5: Sector erase is six writes: AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 8'h30 at any address in the sector. addr[18:16] selects the sector. This opens a collection window of WIN_CYC cycles. Each further single 8'h30 write inside the window adds its sector and restarts the window. When the window expires, the erase runs for ERS_CYC cycles. Every collected sector then reads 8'hFF and every other sector is unchanged.
- R6: A write other than 8'h30 inside the collection window ends it. The block returns to read mode and no sector is erased.
- R7: Chip erase is the sixth write of 8'h10 at 16'h555. The erase starts at once and sets all 8 sectors to 8'hFF.
- R8: Status byte layout: bit 7 is polling, bit 6 is toggle, bit 5 is time limit, bit 3 is erase started, and the other bits are 0. During a program, bit 7 is the complement of bit 7 of the data being written. During the window and the erase, bit 7 is 0.
- R9: Bit 6 inverts after every read while busy. Once the operation ends, successive reads are identical.
- R10: A program that would need a bit to change from 0 to 1 fails. After LIMIT_CYC cycles, bit 5 reads 1 and the byte is unchanged. From then on, reads return status and every write except 8'hF0 is ignored. A write of 8'hF0 returns the block to read mode.
- R11: Bit 3 is 0 while the window is open and 1 while the erase runs. All writes during an erase or a program are ignored.
- R12: A wrong unlock write, or 8'hF0 part way through a sequence, returns the block to read mode without starting any operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; block powers up in read mode |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address; [18:16] sector, [15:0] command decode |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Array byte in read mode, status byte while busy |

## Verification
The bench programs every byte of every sector with a computed pattern and checks the status byte immediately after each program: polling polarity, toggle inversion, and zero in the other bits. A block with the wrong polarity, or with a toggle that ignores reads, fails there. It adds a second sector late in the collection window and reads the status after the first window would have expired. A design that does not restart the timer would show the erase-started bit too early. The bench also writes a program sequence while an erase is running, moves address and data in the middle of one write pulse, interrupts the window, and forces a program failure. Each of these checks reads the array back afterwards, so a block that obeys an ignored write, latches the wrong edge, erases after an abort, or leaves the failed state without 8'hF0 produces a mismatched byte.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW         = 19,
  parameter int SECT_BYTES = 16,
  parameter int WIN_CYC    = 40,
  parameter int ERS_CYC    = 60,
  parameter int PROG_CYC   = 10,
  parameter int LIMIT_CYC  = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int NSECT = 8;
  localparam int OW    = $clog2(SECT_BYTES);
  localparam int IW    = 3 + OW;
  localparam int DEPTH = NSECT * SECT_BYTES;
  localparam int M1    = (WIN_CYC > ERS_CYC) ? WIN_CYC : ERS_CYC;
  localparam int M2    = (PROG_CYC > LIMIT_CYC) ? PROG_CYC : LIMIT_CYC;
  localparam int CW    = $clog2(((M1 > M2) ? M1 : M2) + 1);

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PSET, S_ESET, S_EU1, S_EU2, S_WIN, S_ERASE, S_PGM, S_FAIL
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [NSECT-1:0] smask;
  logic [IW-1:0]    pa;
  logic [7:0]       pd;
  logic             pbad, tog, wr_q, rd_q;
  logic [AW-1:0]    lat_a;
  logic [7:0]       lat_d;
  logic [7:0]       mem [DEPTH];

  wire wr_act   = ~ce_n & ~we_n & oe_n;
  wire rd_act   = ~ce_n & ~oe_n & we_n;
  wire wr_start = wr_act & ~wr_q;
  wire wr_end   = wr_q & ~wr_act;
  wire rd_end   = rd_q & ~rd_act;

  wire [AW-4:0] cmd_a = lat_a[AW-4:0];
  wire          a555  = cmd_a == (AW-3)'(16'h555);
  wire          a2aa  = cmd_a == (AW-3)'(16'h2AA);
  wire [2:0]    l_sec = lat_a[AW-1:AW-3];
  wire [IW-1:0] l_idx = {l_sec, lat_a[OW-1:0]};
  wire [IW-1:0] r_idx = {addr[AW-1:AW-3], addr[OW-1:0]};

  wire busy     = (st == S_WIN) | (st == S_ERASE) | (st == S_PGM) | (st == S_FAIL);
  wire in_win   = st == S_WIN;
  wire erasing  = st == S_ERASE;
  wire failed   = st == S_FAIL;
  wire cnt_zero = cnt == '0;

  wire       poll = ((st == S_PGM) | (st == S_FAIL)) ? ~pd[7] : 1'b0;
  wire [7:0] stat = {poll, tog, failed, 1'b0, erasing, 3'b000};

  assign rdata = busy ? stat : mem[r_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      lat_a <= '0;
      lat_d <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_start) lat_a <= addr;
      if (wr_act)   lat_d <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_READ;
      cnt   <= '0;
      smask <= '0;
      pa    <= '0;
      pd    <= '0;
      pbad  <= 1'b0;
      tog   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (rd_end && busy) tog <= ~tog;

      case (st)
        S_WIN: begin
          if (cnt_zero) begin
            st  <= S_ERASE;
            cnt <= CW'(ERS_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_ERASE: begin
          if (cnt_zero) begin
            for (int s = 0; s < NSECT; s++)
              for (int b = 0; b < SECT_BYTES; b++)
                if (smask[s]) mem[s*SECT_BYTES + b] <= 8'hFF;
            st <= S_READ;
          end else cnt <= cnt - 1'b1;
        end
        S_PGM: begin
          if (cnt_zero) begin
            if (pbad) st <= S_FAIL;
            else begin
              mem[pa] <= mem[pa] & pd;
              st      <= S_READ;
            end
          end else cnt <= cnt - 1'b1;
        end
        default: ;
      endcase

      if (wr_end) begin
        case (st)
          S_READ: if (a555 && lat_d == 8'hAA) st <= S_U1;
          S_U1:   st <= (a2aa && lat_d == 8'h55) ? S_U2 : S_READ;
          S_U2: begin
            if (a555 && lat_d == 8'hA0)      st <= S_PSET;
            else if (a555 && lat_d == 8'h80) st <= S_ESET;
            else                             st <= S_READ;
          end
          S_PSET: begin
            pa   <= l_idx;
            pd   <= lat_d;
            pbad <= |(lat_d & ~mem[l_idx]);
            cnt  <= (|(lat_d & ~mem[l_idx])) ? CW'(LIMIT_CYC - 1) : CW'(PROG_CYC - 1);
            st   <= S_PGM;
          end
          S_ESET: st <= (a555 && lat_d == 8'hAA) ? S_EU1 : S_READ;
          S_EU1:  st <= (a2aa && lat_d == 8'h55) ? S_EU2 : S_READ;
          S_EU2: begin
            if (a555 && lat_d == 8'h10) begin
              smask <= '1;
              cnt   <= CW'(ERS_CYC - 1);
              st    <= S_ERASE;
            end else if (lat_d == 8'h30) begin
              smask <= NSECT'(1) << l_sec;
              cnt   <= CW'(WIN_CYC - 1);
              st    <= S_WIN;
            end else st <= S_READ;
          end
          S_WIN: begin
            if (lat_d == 8'h30) begin
              smask[l_sec] <= 1'b1;
              cnt          <= CW'(WIN_CYC - 1);
              st           <= S_WIN;
            end else st <= S_READ;
          end
          S_FAIL: if (lat_d == 8'hF0) st <= S_READ;
          default: ;
        endcase
      end
    end
  end
endmodule

module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       in_win,
  input logic       erasing,
  input logic       failed,
  input logic       rd_end,
  input logic       wr_end,
  input logic       cnt_zero,
  input logic       tog,
  input logic [7:0] lat_d,
  input logic [7:0] rdata
);
  // R9
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_end) |=> (tog != $past(tog)));
  // R10
  limit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !failed) |-> !rdata[5]);
  // R10
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (failed && !(wr_end && lat_d == 8'hF0)) |=> failed);
  // R11
  timer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erasing |-> rdata[3]);
  // R11
  timer_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> !rdata[3]);
  // R11
  erase_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && !cnt_zero) |=> erasing);
  // R6
  win_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && wr_end && lat_d != 8'h30) |=> !busy);
  // R8
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing || in_win) |-> !rdata[7]);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .in_win(in_win), .erasing(erasing),
  .failed(failed), .rd_end(rd_end), .wr_end(wr_end), .cnt_zero(cnt_zero),
  .tog(tog), .lat_d(lat_d), .rdata(rdata)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int WIN = 40, ERS = 60, PRG = 10, LIM = 25, SB = 16;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] bm [128];

  always #10 clk = ~clk;

  flash_cmd_seq #(.AW(19), .SECT_BYTES(SB), .WIN_CYC(WIN), .ERS_CYC(ERS),
                  .PROG_CYC(PRG), .LIMIT_CYC(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  function automatic logic [18:0] A(input int s, input int o);
    return {s[2:0], 12'h000, o[3:0]};
  endfunction

  function automatic logic [7:0] pat(input int s, input int o);
    return 8'((s*37 + o*11 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d,
                    input logic oe = 1'b1, input logic ce = 1'b0);
    @(negedge clk); addr = a; wdata = d; ce_n = ce; oe_n = oe; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [18:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); d = rdata; oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic pgm(input int s, input int o, input logic [7:0] d);
    wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(A(s, o), d);
  endtask

  task automatic epre();
    wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'h80);
    wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55);
  endtask

  task automatic sweep(input string tag);
    logic [7:0] v;
    for (int s = 0; s < 8; s++)
      for (int o = 0; o < SB; o++) begin
        rd(A(s, o), v);
        chk(v == bm[s*SB+o], tag, v, bm[s*SB+o]);
      end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    for (int i = 0; i < 128; i++) bm[i] = 8'hFF;
    idle(3); rst_n = 1'b1; idle(2);

    // R1 reset state: erased array, read mode
    sweep("R1 reset read");

    // R4 R8 R9 program every byte, status during and data after
    for (int s = 0; s < 8; s++)
      for (int o = 0; o < SB; o++) begin
        logic [7:0] d;
        d = pat(s, o);
        pgm(s, o, d);
        rd(A(s, o), v); rd(A(s, o), v2);
        chk(v[7] == ~d[7], "R8 program poll", v[7], ~d[7]);
        chk((v & 8'h3F) == 8'h00, "R8 status zero bits", v & 8'h3F, 0);
        chk(v[6] != v2[6], "R9 toggle while busy", v2[6], ~v[6]);
        idle(PRG + 2);
        bm[s*SB+o] = d;
        rd(A(s, o), v); rd(A(s, o), v2);
        chk(v == d, "R4 programmed byte", v, d);
        chk(v == v2, "R9 toggle stopped", v2, v);
      end
    sweep("R4 full array");

    // R4 program clears only bits
    pgm(0, 1, pat(0, 1) & 8'hF0); idle(PRG + 6);
    bm[1] = pat(0, 1) & 8'hF0;
    rd(A(0, 1), v); chk(v == bm[1], "R4 and-merge", v, bm[1]);

    // R6 window abort
    epre(); wr(A(3, 0), 8'h30);
    wr(19'h555, 8'hAA);
    rd(A(3, 0), v); chk(v == bm[3*SB], "R6 read mode after abort", v, bm[3*SB]);
    idle(WIN + ERS + 5);
    sweep("R6 no erase after abort");

    // R10 failed program (0 -> 1 needed)
    pgm(5, 2, 8'hFF);
    rd(A(5, 2), v); chk(v[5] == 1'b0, "R10 limit bit early", v[5], 0);
    idle(LIM + 5);
    rd(A(5, 2), v); chk(v[5] == 1'b1, "R10 limit bit set", v[5], 1);
    chk(v[7] == 1'b0, "R8 poll on failed program", v[7], 0);
    pgm(5, 3, 8'h00); idle(PRG + 5);
    rd(A(5, 3), v); chk(v[5] == 1'b1, "R10 writes ignored when failed", v[5], 1);
    wr(19'h0, 8'hF0);
    rd(A(5, 2), v); chk(v == bm[5*SB+2], "R10 byte unchanged", v, bm[5*SB+2]);
    rd(A(5, 3), v); chk(v == bm[5*SB+3], "R10 other byte unchanged", v, bm[5*SB+3]);

    // R5 R11 sector erase with window restart and ignored writes
    epre(); wr(A(1, 4), 8'h30);
    rd(A(1, 0), v);
    chk(v[3] == 1'b0 && v[7] == 1'b0, "R11 window status", v, 0);
    idle(WIN - 12);
    wr(A(6, 7), 8'h30);
    idle(15);
    rd(A(1, 0), v); chk(v[3] == 1'b0, "R5 window restarted", v[3], 0);
    idle(WIN);
    rd(A(1, 0), v); chk(v[3] == 1'b1 && v[7] == 1'b0, "R11 erase started", v, 8'h08);
    pgm(0, 0, 8'h00);
    rd(A(1, 0), v); chk(v[3] == 1'b1, "R11 still erasing", v[3], 1);
    idle(ERS + 10);
    for (int o = 0; o < SB; o++) begin bm[1*SB+o] = 8'hFF; bm[6*SB+o] = 8'hFF; end
    sweep("R5 sector erase result");

    // R3 address from first active cycle, data from last
    wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0);
    @(negedge clk); addr = A(1, 9); wdata = 8'h3C; ce_n = 0; we_n = 0;
    @(negedge clk); addr = A(1, 10); wdata = 8'h5A;
    @(negedge clk); we_n = 1; ce_n = 1;
    idle(PRG + 4);
    rd(A(1, 9), v);  chk(v == 8'h5A, "R3 latched address/data", v, 8'h5A);
    rd(A(1, 10), v); chk(v == 8'hFF, "R3 late address unused", v, 8'hFF);
    bm[1*SB+9] = 8'h5A;

    // R2 qualified writes only
    wr(19'h555, 8'hAA, 1'b0); wr(19'h2AA, 8'h55, 1'b0);
    wr(19'h555, 8'hA0, 1'b0); wr(A(1, 11), 8'h00, 1'b0);
    idle(PRG + 4);
    rd(A(1, 11), v); chk(v == 8'hFF, "R2 oe low write ignored", v, 8'hFF);
    wr(19'h555, 8'hAA, 1'b1, 1'b1); wr(19'h2AA, 8'h55, 1'b1, 1'b1);
    wr(19'h555, 8'hA0, 1'b1, 1'b1); wr(A(1, 11), 8'h00, 1'b1, 1'b1);
    idle(PRG + 4);
    rd(A(1, 11), v); chk(v == 8'hFF, "R2 ce high write ignored", v, 8'hFF);

    // R12 broken sequences
    wr(19'h555, 8'hAA); wr(19'h2AA, 8'h56); wr(19'h555, 8'hA0); wr(A(1, 12), 8'h00);
    idle(PRG + 4);
    rd(A(1, 12), v); chk(v == 8'hFF, "R12 bad unlock", v, 8'hFF);
    wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'hF0);
    wr(19'h555, 8'hA0); wr(A(1, 12), 8'h00);
    idle(PRG + 4);
    rd(A(1, 12), v); chk(v == 8'hFF, "R12 reset mid sequence", v, 8'hFF);

    // R7 chip erase
    epre(); wr(19'h555, 8'h10);
    rd(A(2, 0), v); chk(v[3] == 1'b1, "R7 chip erase starts at once", v[3], 1);
    idle(ERS + 5);
    for (int i = 0; i < 128; i++) bm[i] = 8'hFF;
    sweep("R7 chip erase result");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule